// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block is an eight-slot, fully associative cache of virtual-to-physical page translations. Each slot holds a 20-bit virtual page number, a 20-bit physical frame number and the 8-bit address-space identifier that was supplied when the slot was written. A combinational lookup port takes a 32-bit virtual address together with the identifier of the running context. It reports a hit and returns the physical address made from the cached frame number and the 12-bit in-page offset.

Because every slot carries its own identifier, translations from several contexts can sit in the cache together, and switching contexts needs no flush. After a miss, a fill port writes a new translation. The fill goes to the lowest-numbered empty slot, or, when every slot is occupied, to the slot named by a rotating replacement pointer.

A maintenance port removes translations. It can drop one page belonging to one context, drop every page inside an inclusive page-number range whatever its context, or empty the whole cache. Walking the page tables, permission checks and large pages are left to other blocks.

Top module: `asid_tlb`

## Requirements
- R1: After reset no slot is occupied, and every lookup reports a miss.
- R2: A lookup hits only when a slot holds both the lookup page number (address bits 31:12) and the lookup identifier. On a hit the physical address is the stored frame number in bits 31:12 and the lookup address bits 11:0 in bits 11:0.
- R3: A slot holding the right page number under a different identifier gives a miss.
- R4: Changing the lookup identifier removes nothing, so a translation hits again once its identifier is presented again.
- R5: A fill writes the lowest-numbered empty slot whenever one exists, and then evicts nothing.
- R6: A fill into a full cache replaces the slot named by a rotating pointer. The pointer is 0 after reset, advances by one only on such a replacement, and wraps from 7 to 0.
- R7: Maintenance code 1 (single page) removes only the slot whose page number and identifier both equal the supplied page number and identifier. The same page under another identifier stays.
- R8: Maintenance code 2 (range) removes every slot whose page number lies between the supplied start and end, both ends included, whatever its identifier.
- R9: Maintenance code 3 (flush) removes every slot. Code 0 does nothing.
- R10: When a fill and a maintenance command arrive in the same cycle, the command is also applied to the translation being written, so a covered fill is dropped. A fill the command does not cover still lands.
- R11: Fills and maintenance take effect at the next rising clock edge, while lookup is combinational, so a translation filled in a cycle cannot hit during that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| lk_vaddr | input | 32 | Lookup virtual address |
| lk_asid | input | 8 | Identifier of the running context |
| lk_hit | output | 1 | Lookup hit |
| lk_paddr | output | 32 | Translated physical address (frame bits are zero on a miss) |
| fill_en | input | 1 | Write a translation this cycle |
| fill_vpn | input | 20 | Virtual page number to write |
| fill_pfn | input | 20 | Physical frame number to write |
| fill_asid | input | 8 | Identifier to write |
| inv_op | input | 2 | Maintenance code: 0 none, 1 single page, 2 range, 3 flush |
| inv_vpn_lo | input | 20 | Page to drop (code 1) or range start (code 2) |
| inv_vpn_hi | input | 20 | Inclusive range end (code 2) |
| inv_asid | input | 8 | Identifier for code 1 |

## Verification
The assertions assume that the fill port never writes a page number and identifier pair that is already cached and has not been removed in that same cycle. Under that assumption, at most one slot can match any lookup. The stimulus keeps to this rule: every fill uses a page number and identifier pair that is not cached at that moment, each scenario starts from a flush, and evicted or removed pairs are reused only after the bench has confirmed that they miss. Range commands are always issued with start no greater than end.

// File: rtl/tlb_pkg.sv
// Package: shared maintenance-command encoding for the translation cache.
// Assumes: the encoding is the one listed in the brief (0 none, 1 page,
// 2 range, 3 flush).
package tlb_pkg;

    typedef enum logic [1:0] {
        INV_NONE  = 2'd0,
        INV_PAGE  = 2'd1,
        INV_RANGE = 2'd2,
        INV_ALL   = 2'd3
    } inv_op_e;

endpackage

// File: rtl/tlb_slot.sv
// Module: one cache slot. Holds page, frame, identifier and an occupied flag.
// It compares itself against the lookup and applies maintenance to its
// next-cycle contents, so a fill covered by a same-cycle command is dropped.
// Assumes: wr_en is asserted for at most one slot per cycle.
module tlb_slot #(
    parameter int VPN_W  = 20,
    parameter int PFN_W  = 20,
    parameter int ASID_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic              wr_en,
    input  logic [VPN_W-1:0]  wr_vpn,
    input  logic [PFN_W-1:0]  wr_pfn,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic [1:0]        inv_op,
    input  logic [VPN_W-1:0]  inv_vpn_lo,
    input  logic [VPN_W-1:0]  inv_vpn_hi,
    input  logic [ASID_W-1:0] inv_asid,
    output logic              valid,
    output logic              match,
    output logic [PFN_W-1:0]  pfn
);
    import tlb_pkg::*;

    logic [VPN_W-1:0]  vpn_q, vpn_n;
    logic [ASID_W-1:0] asid_q, asid_n;
    logic [PFN_W-1:0]  pfn_n;
    logic              valid_n, kill;

    // Next contents: a fill replaces the slot, otherwise it holds.
    always_comb begin
        vpn_n   = wr_en ? wr_vpn  : vpn_q;
        asid_n  = wr_en ? wr_asid : asid_q;
        pfn_n   = wr_en ? wr_pfn  : pfn;
        valid_n = wr_en | valid;
    end

    // Maintenance decision, taken against the next contents.
    always_comb begin
        unique case (inv_op)
            INV_PAGE:  kill = (vpn_n == inv_vpn_lo) && (asid_n == inv_asid);
            INV_RANGE: kill = (vpn_n >= inv_vpn_lo) && (vpn_n <= inv_vpn_hi);
            INV_ALL:   kill = 1'b1;
            default:   kill = 1'b0;
        endcase
    end

    // Slot registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid  <= 1'b0;
            vpn_q  <= '0;
            asid_q <= '0;
            pfn    <= '0;
        end else begin
            valid  <= valid_n & ~kill;
            vpn_q  <= vpn_n;
            asid_q <= asid_n;
            pfn    <= pfn_n;
        end
    end

    // Lookup compare: page and identifier must both agree.
    always_comb match = valid && (vpn_q == lk_vpn) && (asid_q == lk_asid);

endmodule

// File: rtl/tlb_victim.sv
// Module: picks the slot a fill writes. The lowest-numbered empty slot wins;
// with none empty, a rotating pointer names the slot to replace.
// Assumes: ENTRIES >= 2. The pointer moves only on a fill into a full cache.
module tlb_victim #(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] valid,
    input  logic               fill_en,
    output logic [IDX_W-1:0]   sel_idx
);
    logic [IDX_W-1:0] rr_q;
    logic [IDX_W-1:0] free_idx;
    logic             free_found;

    // Priority search for the lowest empty slot.
    always_comb begin
        free_found = 1'b0;
        free_idx   = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (!valid[i] && !free_found) begin
                free_found = 1'b1;
                free_idx   = IDX_W'(i);
            end
        end
        sel_idx = free_found ? free_idx : rr_q;
    end

    // Rotating replacement pointer, wrapping at the last slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_q <= '0;
        end else if (fill_en && !free_found) begin
            rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
        end
    end

endmodule

// File: rtl/tlb_hitmux.sv
// Module: merges the per-slot compare results into a hit flag and a
// physical address. Assumes at most one slot matches, so an OR merge is exact.
module tlb_hitmux #(
    parameter int ENTRIES = 8,
    parameter int PFN_W   = 20,
    parameter int OFF_W   = 12
) (
    input  logic [ENTRIES-1:0]            match,
    input  logic [ENTRIES-1:0][PFN_W-1:0] pfn,
    input  logic [OFF_W-1:0]              offset,
    output logic                          hit,
    output logic [PFN_W+OFF_W-1:0]        paddr
);
    logic [PFN_W-1:0] pfn_sel;

    // OR-merge of the frame number of the matching slot.
    always_comb begin
        pfn_sel = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) pfn_sel = pfn_sel | pfn[i];
        end
        hit   = |match;
        paddr = {pfn_sel, offset};
    end

endmodule

// File: rtl/asid_tlb.sv
// Module: top of the identifier-tagged translation cache. Instantiates one
// slot per entry, the fill-slot chooser and the hit merge.
// Assumes: no fill duplicates a cached page/identifier pair; range start is
// not above range end.
module asid_tlb #(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 20,
    parameter int ASID_W  = 8,
    parameter int OFF_W   = 12,
    localparam int VA_W   = VPN_W + OFF_W,
    localparam int PA_W   = PFN_W + OFF_W,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VA_W-1:0]   lk_vaddr,
    input  logic [ASID_W-1:0] lk_asid,
    output logic              lk_hit,
    output logic [PA_W-1:0]   lk_paddr,
    input  logic              fill_en,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [PFN_W-1:0]  fill_pfn,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic [1:0]        inv_op,
    input  logic [VPN_W-1:0]  inv_vpn_lo,
    input  logic [VPN_W-1:0]  inv_vpn_hi,
    input  logic [ASID_W-1:0] inv_asid
);
    logic [ENTRIES-1:0]            valid_vec;
    logic [ENTRIES-1:0]            match_vec;
    logic [ENTRIES-1:0][PFN_W-1:0] pfn_vec;
    logic [IDX_W-1:0]              sel_idx;

    tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid   (valid_vec),
        .fill_en (fill_en),
        .sel_idx (sel_idx)
    );

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        logic wr_this;
        // Write strobe for this slot.
        always_comb wr_this = fill_en && (sel_idx == IDX_W'(g));

        tlb_slot #(.VPN_W(VPN_W), .PFN_W(PFN_W), .ASID_W(ASID_W)) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .lk_vpn     (lk_vaddr[VA_W-1:OFF_W]),
            .lk_asid    (lk_asid),
            .wr_en      (wr_this),
            .wr_vpn     (fill_vpn),
            .wr_pfn     (fill_pfn),
            .wr_asid    (fill_asid),
            .inv_op     (inv_op),
            .inv_vpn_lo (inv_vpn_lo),
            .inv_vpn_hi (inv_vpn_hi),
            .inv_asid   (inv_asid),
            .valid      (valid_vec[g]),
            .match      (match_vec[g]),
            .pfn        (pfn_vec[g])
        );
    end

    tlb_hitmux #(.ENTRIES(ENTRIES), .PFN_W(PFN_W), .OFF_W(OFF_W)) u_mux (
        .match  (match_vec),
        .pfn    (pfn_vec),
        .offset (lk_vaddr[OFF_W-1:0]),
        .hit    (lk_hit),
        .paddr  (lk_paddr)
    );

endmodule

// File: rtl/asid_tlb_chk.sv
// Module: assertion checker bound to asid_tlb. Observes slot occupancy,
// per-slot compare results and the command ports.
// Assumes: the input rules stated in the brief's verification section.
module asid_tlb_chk #(
    parameter int ENTRIES = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ENTRIES-1:0] valid_vec,
    input logic [ENTRIES-1:0] match_vec,
    input logic               fill_en,
    input logic [1:0]         inv_op,
    input logic               lk_hit
);
    // At most one slot may answer a lookup (R2).
    assert_single_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match_vec));

    // A hit needs an occupied slot (R1).
    assert_hit_needs_entry_R1: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (valid_vec != '0));

    // A flush leaves every slot empty, fill or not (R9, R10).
    assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_op == 2'd3) |=> (valid_vec == '0));

    // A plain fill into a cache with room adds exactly one entry (R5).
    assert_fill_adds_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && inv_op == 2'd0 && !(&valid_vec))
        |=> ($countones(valid_vec) == $countones($past(valid_vec)) + 1));

    // A fill into a full cache keeps it full (R6).
    assert_replace_keeps_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && inv_op == 2'd0 && (&valid_vec)) |=> (&valid_vec));

    // Without a command, occupancy holds and lookups change nothing (R4, R11).
    assert_idle_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!fill_en && inv_op == 2'd0) |=> $stable(valid_vec));

    // Maintenance alone never adds entries (R7, R8).
    assert_inv_no_growth_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!fill_en && inv_op != 2'd0)
        |=> ($countones(valid_vec) <= $countones($past(valid_vec))));

endmodule

bind asid_tlb asid_tlb_chk #(.ENTRIES(ENTRIES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_vec (valid_vec),
    .match_vec (match_vec),
    .fill_en   (fill_en),
    .inv_op    (inv_op),
    .lk_hit    (lk_hit)
);

// File: tb/sim_asid_tlb.sv
// Bench: directed sweeps over the eight-slot cache with arithmetic expected
// frame numbers.
module sim_asid_tlb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic [7:0]  lk_asid = '0;
    logic        lk_hit;
    logic [31:0] lk_paddr;
    logic        fill_en = 1'b0;
    logic [19:0] fill_vpn = '0;
    logic [19:0] fill_pfn = '0;
    logic [7:0]  fill_asid = '0;
    logic [1:0]  inv_op = '0;
    logic [19:0] inv_vpn_lo = '0;
    logic [19:0] inv_vpn_hi = '0;
    logic [7:0]  inv_asid = '0;

    int checks = 0;
    int errors = 0;

    asid_tlb u0 (
        .clk(clk), .rst_n(rst_n), .lk_vaddr(lk_vaddr), .lk_asid(lk_asid),
        .lk_hit(lk_hit), .lk_paddr(lk_paddr), .fill_en(fill_en),
        .fill_vpn(fill_vpn), .fill_pfn(fill_pfn), .fill_asid(fill_asid),
        .inv_op(inv_op), .inv_vpn_lo(inv_vpn_lo), .inv_vpn_hi(inv_vpn_hi),
        .inv_asid(inv_asid)
    );

    always #10 clk = ~clk;

    // Frame number the bench assigns to a page/identifier pair.
    function automatic logic [19:0] pf(input logic [19:0] v, input logic [7:0] a);
        return 20'(v * 3 + 20'h40000 + {12'd0, a});
    endfunction

    // One cycle of fill and/or maintenance, ending at a falling edge.
    task automatic cmd(input logic f, input logic [19:0] v, input logic [7:0] a,
                       input logic [1:0] op, input logic [19:0] lo,
                       input logic [19:0] hi, input logic [7:0] ia);
        @(negedge clk);
        fill_en = f; fill_vpn = v; fill_pfn = pf(v, a); fill_asid = a;
        inv_op = op; inv_vpn_lo = lo; inv_vpn_hi = hi; inv_asid = ia;
        @(negedge clk);
        fill_en = 1'b0; inv_op = 2'd0;
    endtask

    task automatic fill(input logic [19:0] v, input logic [7:0] a);
        cmd(1'b1, v, a, 2'd0, 20'd0, 20'd0, 8'd0);
    endtask

    // Combinational lookup check, away from the clock edge.
    task automatic look(input logic [19:0] v, input logic [7:0] a,
                        input logic exp_hit, input string req);
        logic [11:0] off;
        logic [31:0] exp_pa;
        off = 12'(v * 7 + 12'h35);
        lk_vaddr = {v, off}; lk_asid = a;
        #2;
        exp_pa = exp_hit ? {pf(v, a), off} : {20'd0, off};
        checks++;
        if (lk_hit !== exp_hit || (exp_hit && lk_paddr !== exp_pa)) begin
            errors++;
            $display("FAIL %s vpn=%h asid=%0d: hit=%b paddr=%h expected hit=%b paddr=%h",
                     req, v, a, lk_hit, lk_paddr, exp_hit, exp_pa);
        end
    endtask

    function automatic logic [7:0] alt(input int i);
        return (i % 2 == 1) ? 8'd7 : 8'd3;
    endfunction

    initial begin : watchdog
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: empty after reset
        look(20'h0, 8'd0, 1'b0, "R1");
        look(20'hAA, 8'd1, 1'b0, "R1");

        // R11: no hit in the fill cycle, hit after the edge
        @(negedge clk);
        fill_en = 1'b1; fill_vpn = 20'hAA; fill_pfn = pf(20'hAA, 8'd1); fill_asid = 8'd1;
        look(20'hAA, 8'd1, 1'b0, "R11");
        @(negedge clk);
        fill_en = 1'b0;
        look(20'hAA, 8'd1, 1'b1, "R11");

        // R9: flush
        cmd(1'b0, 20'd0, 8'd0, 2'd3, 20'd0, 20'd0, 8'd0);
        look(20'hAA, 8'd1, 1'b0, "R9");

        // R2/R3 sweep: eight slots, two identifiers
        for (int i = 0; i < 8; i++) fill(20'h100 + 20'(i), alt(i));
        for (int i = 0; i < 8; i++) begin
            look(20'h100 + 20'(i), 8'd3, alt(i) == 8'd3, "R2");
            look(20'h100 + 20'(i), 8'd7, alt(i) == 8'd7, "R3");
        end
        // R4: switch identifier and back
        look(20'h100, 8'd7, 1'b0, "R4");
        look(20'h100, 8'd3, 1'b1, "R4");

        // R6: replacement from pointer 0, then 1
        fill(20'h200, 8'd3);
        look(20'h100, 8'd3, 1'b0, "R6");
        look(20'h200, 8'd3, 1'b1, "R6");
        look(20'h101, 8'd7, 1'b1, "R6");
        fill(20'h201, 8'd3);
        look(20'h101, 8'd7, 1'b0, "R6");
        // R5: freed slot 5 is reused, pointer not moved
        cmd(1'b0, 20'd0, 8'd0, 2'd1, 20'h105, 20'd0, 8'd7);
        look(20'h105, 8'd7, 1'b0, "R7");
        fill(20'h202, 8'd3);
        look(20'h202, 8'd3, 1'b1, "R5");
        look(20'h102, 8'd3, 1'b1, "R5");
        fill(20'h203, 8'd3);
        look(20'h102, 8'd3, 1'b0, "R6");
        look(20'h103, 8'd7, 1'b1, "R6");
        // R6: wrap of the pointer from 7 to 0
        for (int i = 0; i < 5; i++) fill(20'h210 + 20'(i), 8'd3);
        look(20'h200, 8'd3, 1'b1, "R6");
        fill(20'h220, 8'd3);
        look(20'h200, 8'd3, 1'b0, "R6");
        look(20'h201, 8'd3, 1'b1, "R6");

        // R7: single page only for its identifier
        cmd(1'b0, 20'd0, 8'd0, 2'd3, 20'd0, 20'd0, 8'd0);
        fill(20'h300, 8'd1);
        fill(20'h300, 8'd2);
        fill(20'h301, 8'd1);
        cmd(1'b0, 20'd0, 8'd0, 2'd1, 20'h300, 20'd0, 8'd2);
        look(20'h300, 8'd1, 1'b1, "R7");
        look(20'h300, 8'd2, 1'b0, "R7");
        look(20'h301, 8'd1, 1'b1, "R7");
        cmd(1'b0, 20'd0, 8'd0, 2'd1, 20'h301, 20'd0, 8'd9);
        look(20'h301, 8'd1, 1'b1, "R7");
        // R9: code 0 does nothing
        cmd(1'b0, 20'd0, 8'd0, 2'd0, 20'h0, 20'hFFFFF, 8'd1);
        look(20'h300, 8'd1, 1'b1, "R9");

        // R8: inclusive range, any identifier
        cmd(1'b0, 20'd0, 8'd0, 2'd3, 20'd0, 20'd0, 8'd0);
        for (int i = 0; i < 6; i++) fill(20'h400 + 20'(i), 8'(1 + i % 2));
        cmd(1'b0, 20'd0, 8'd0, 2'd2, 20'h401, 20'h403, 8'd0);
        for (int i = 0; i < 6; i++)
            look(20'h400 + 20'(i), 8'(1 + i % 2), (i == 0) || (i > 3), "R8");

        // R10: fill covered by the same-cycle command is dropped
        cmd(1'b1, 20'h500, 8'd1, 2'd2, 20'h4F0, 20'h50F, 8'd0);
        look(20'h500, 8'd1, 1'b0, "R10");
        look(20'h404, 8'd1, 1'b1, "R10");
        cmd(1'b1, 20'h501, 8'd1, 2'd1, 20'h404, 20'd0, 8'd1);
        look(20'h501, 8'd1, 1'b1, "R10");
        look(20'h404, 8'd1, 1'b0, "R10");
        cmd(1'b1, 20'h502, 8'd2, 2'd3, 20'd0, 20'd0, 8'd0);
        look(20'h502, 8'd2, 1'b0, "R10");
        look(20'h501, 8'd1, 1'b0, "R9");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule